// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a pixel coordinate into the byte address at which that pixel sits in a tiled or linear surface. A request carries the column and row, the row pitch in bytes, a layout mode, the element size as a power of two, and a swizzle enable. The block splits the coordinate into a tile position and a position inside the 4 KB tile. It interleaves the in-tile bits in the pattern of the selected layout and places tiles row-major across the surface. For X and Y layouts it can fold higher address bits into bit 6.

A request may also ask for a rectangle. The block then walks the rectangle in raster order, from left to right within a row and from top to bottom, and emits one address per cycle. It marks the bottom-right pixel as last. Requests and results each use a valid/ready handshake. The two register stages stall together when the consumer holds off.

Top module: `tsa_addr_gen`

## Requirements
- R1: After reset, out_valid is 0 and req_ready is 1 while out_ready is 1.
- R2: Mode code 0 (linear) gives address = y × pitch + x × 2^bpp. The swizzle enable has no effect in this mode.
- R3: Mode code 1 (X layout) uses a tile 512 bytes wide and 8 rows high. With byte column u = x × 2^bpp and in-tile row v = y mod 8, the in-tile bits [11:0] are v2 v1 v0 u8..u0. The tile number is (y / 8) × (pitch / 512) + (u / 512), and the address is tile × 4096 plus the in-tile offset.
- R4: Mode code 2 (Y layout) uses a tile 128 bytes wide and 32 rows high. The in-tile bits [11:0] are u6 u5 u4 v4..v0 u3..u0. The tile number is (y / 32) × (pitch / 128) + (u / 128).
- R5: Mode code 3 (W layout) uses a tile of 64 × 64 one-byte elements. Here u = x mod 64 and v = y mod 64, and bpp is ignored. The in-tile bits [11:0] are u5 u4 u3 v5 v4 v3 v2 u2 v1 u1 v0 u0. The tile number is (y / 64) × (pitch / 128) + (x / 64), where pitch is the programmed value of twice the width in bytes.
- R6: The bpp field selects an element of 1, 2, 4, 8 or 16 bytes (codes 0 to 4, with larger codes treated as 4). The byte column is x shifted left by bpp, so the lowest bpp in-tile bits are zero in X and Y layouts.
- R7: With swizzle enabled in X layout, address bit 6 is XORed with address bits 9 and 10.
- R8: With swizzle enabled in Y layout, address bit 6 is XORed with bit 9 only. The swizzle enable has no effect in W layout.
- R9: A request accepted at a clock edge, with the output path free, shows its address on out_valid after the next clock edge.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_addr and out_last hold their values.
- R11: With walk set, the block emits (wm1 + 1) × (hm1 + 1) addresses in raster order, one per accepted output cycle. req_ready is 0 until the last address has entered the pipeline. With walk clear, wm1 and hm1 are ignored and exactly one address is produced.
- R12: out_last is 1 only on the address of the bottom-right pixel of a walk, and always on the single address of a non-walk request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| req_x | input | XW (14) | Column in elements |
| req_y | input | YW (14) | Row |
| req_pitch | input | PW (16) | Row pitch in bytes |
| req_mode | input | 2 | 0 linear, 1 X, 2 Y, 3 W |
| req_bpp | input | BPPW (3) | log2 of element size in bytes |
| req_swz | input | 1 | Bit-6 swizzle enable |
| req_walk | input | 1 | Walk the rectangle instead of a single pixel |
| req_wm1 | input | XW (14) | Rectangle width minus one |
| req_hm1 | input | YW (14) | Rectangle height minus one |
| out_valid | output | 1 | Address present |
| out_ready | input | 1 | Consumer takes the address at this edge |
| out_addr | output | AW (32) | Byte address |
| out_last | output | 1 | Last address of the request |

## Verification
The bench goes after tile edges where the byte column or row crosses into the next tile. A wrong shift or pitch divide would put such pixels in the neighbouring tile, off by one tile or one whole tile row. It sets bit-9/bit-10 combinations under swizzle, including the case in which both are set and the flip cancels. A design that flips in linear or W mode, or XORs bit 10 in Y mode, gives addresses off by 64. Wide elements in Y layout expose a byte column that is not shifted. Single-column walks expose a wrong end-of-row wrap, which shows as addresses out of order or as a last flag on the wrong pixel. Random stalls expose outputs that are dropped or that change under backpressure.

// File: rtl/tsa_pkg.sv
`timescale 1ns/1ps
package tsa_pkg;

   typedef enum logic [1:0] {
      TM_LINEAR = 2'd0,
      TM_XMAJ   = 2'd1,
      TM_YMAJ   = 2'd2,
      TM_STEN   = 2'd3
   } tile_mode_e;

   // every tile is one 4 KB block
   localparam int TILE_LOG2   = 12;
   // X layout: 512 bytes x 8 rows
   localparam int XT_COL_LOG2 = 9;
   localparam int XT_ROW_LOG2 = 3;
   // Y layout: 128 bytes x 32 rows
   localparam int YT_COL_LOG2 = 7;
   localparam int YT_ROW_LOG2 = 5;
   // W layout: 64 x 64 bytes logical, pitch counted in 128-byte units
   localparam int WT_COL_LOG2 = 6;
   localparam int WT_ROW_LOG2 = 6;
   localparam int WT_PIT_LOG2 = 7;
   // swizzle target bit
   localparam int SWZ_BIT     = 6;

endpackage

// File: rtl/tsa_walker.sv
`timescale 1ns/1ps
module tsa_walker
   import tsa_pkg::*;
#(
   parameter int XW   = 14,
   parameter int YW   = 14,
   parameter int PW   = 16,
   parameter int BPPW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [XW-1:0]   req_x,
   input  logic [YW-1:0]   req_y,
   input  logic [PW-1:0]   req_pitch,
   input  tile_mode_e      req_mode,
   input  logic [BPPW-1:0] req_bpp,
   input  logic            req_swz,
   input  logic            req_walk,
   input  logic [XW-1:0]   req_wm1,
   input  logic [YW-1:0]   req_hm1,
   input  logic            adv,
   output logic            g_valid,
   output logic [XW-1:0]   g_x,
   output logic [YW-1:0]   g_y,
   output logic [PW-1:0]   g_pitch,
   output tile_mode_e      g_mode,
   output logic [BPPW-1:0] g_bpp,
   output logic            g_swz,
   output logic            g_last
);

   logic            busy;
   logic [XW-1:0]   cx, x0_q, xl_q;
   logic [YW-1:0]   cy, yl_q;
   logic [PW-1:0]   pit_q;
   tile_mode_e      mode_q;
   logic [BPPW-1:0] bpp_q;
   logic            swz_q;

   logic [XW-1:0]   ox0, oxl;
   logic [YW-1:0]   oyl;
   logic            row_end, take;

   always_comb begin
      if (busy) begin
         g_x     = cx;
         g_y     = cy;
         ox0     = x0_q;
         oxl     = xl_q;
         oyl     = yl_q;
         g_pitch = pit_q;
         g_mode  = mode_q;
         g_bpp   = bpp_q;
         g_swz   = swz_q;
      end else begin
         g_x     = req_x;
         g_y     = req_y;
         ox0     = req_x;
         oxl     = req_x + (req_walk ? req_wm1 : '0);
         oyl     = req_y + (req_walk ? req_hm1 : '0);
         g_pitch = req_pitch;
         g_mode  = req_mode;
         g_bpp   = req_bpp;
         g_swz   = req_swz;
      end
   end

   assign g_valid   = busy | req_valid;
   assign req_ready = adv & ~busy;
   assign row_end   = (g_x == oxl);
   assign g_last    = row_end && (g_y == oyl);
   assign take      = adv & g_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else if (take) begin
         busy <= ~g_last;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         if (row_end) begin
            cx <= ox0;
            cy <= g_y + 1'b1;
         end else begin
            cx <= g_x + 1'b1;
            cy <= g_y;
         end
         x0_q   <= ox0;
         xl_q   <= oxl;
         yl_q   <= oyl;
         pit_q  <= g_pitch;
         mode_q <= g_mode;
         bpp_q  <= g_bpp;
         swz_q  <= g_swz;
      end
   end

   // R11
   walk_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && !g_last |=> g_valid && !req_ready);

   // R11
   raster_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && !g_last && !row_end |=> (g_x == $past(g_x) + 1'b1) && (g_y == $past(g_y)));

   // R12
   last_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && g_last |=> !busy);

endmodule

// File: rtl/tsa_split.sv
`timescale 1ns/1ps
module tsa_split
   import tsa_pkg::*;
#(
   parameter int XW           = 14,
   parameter int YW           = 14,
   parameter int PW           = 16,
   parameter int BPPW         = 3,
   parameter int MAX_BPP_LOG2 = 4,
   parameter int UBW          = XW + MAX_BPP_LOG2
) (
   input  logic [XW-1:0]   x,
   input  logic [YW-1:0]   y,
   input  logic [PW-1:0]   pitch,
   input  tile_mode_e      mode,
   input  logic [BPPW-1:0] bpp,
   output logic [YW-1:0]   trow,
   output logic [UBW-1:0]  tcol,
   output logic [PW-1:0]   tpr,
   output logic [11:0]     intile
);

   logic [UBW-1:0] ub_opt [MAX_BPP_LOG2+1];
   logic [UBW-1:0] ub;

   // one pre-shifted byte column per element size
   for (genvar k = 0; k <= MAX_BPP_LOG2; k++) begin : g_elem
      assign ub_opt[k] = UBW'(x) << k;
   end

   always_comb begin
      ub = ub_opt[MAX_BPP_LOG2];
      for (int k = 0; k < MAX_BPP_LOG2; k++) begin
         if (int'(bpp) == k) ub = ub_opt[k];
      end
   end

   always_comb begin
      trow   = y;
      tpr    = pitch;
      tcol   = ub;
      intile = '0;
      case (mode)
         TM_XMAJ: begin
            trow   = y >> XT_ROW_LOG2;
            tpr    = pitch >> XT_COL_LOG2;
            tcol   = ub >> XT_COL_LOG2;
            intile = {y[2:0], ub[8:0]};
         end
         TM_YMAJ: begin
            trow   = y >> YT_ROW_LOG2;
            tpr    = pitch >> YT_COL_LOG2;
            tcol   = ub >> YT_COL_LOG2;
            intile = {ub[6:4], y[4:0], ub[3:0]};
         end
         TM_STEN: begin
            trow   = y >> WT_ROW_LOG2;
            tpr    = pitch >> WT_PIT_LOG2;
            tcol   = UBW'(x >> WT_COL_LOG2);
            intile = {x[5:3], y[5:2], x[2], y[1], x[1], y[0], x[0]};
         end
         default: begin
            trow   = y;
            tpr    = pitch;
            tcol   = ub;
            intile = '0;
         end
      endcase
   end

endmodule

// File: rtl/tsa_place.sv
`timescale 1ns/1ps
module tsa_place
   import tsa_pkg::*;
#(
   parameter int YW          = 14,
   parameter int UBW         = 18,
   parameter int PW          = 16,
   parameter int AW          = 32,
   parameter bit SWZ_SUPPORT = 1'b1
) (
   input  tile_mode_e      mode,
   input  logic            swz,
   input  logic [YW-1:0]   trow,
   input  logic [UBW-1:0]  tcol,
   input  logic [PW-1:0]   tpr,
   input  logic [11:0]     intile,
   output logic [AW-1:0]   addr
);

   logic [AW-1:0] prod;
   logic [AW-1:0] tiled;
   logic          flip;

   // linear: row*pitch + byte column; tiled: tile row*tiles per row + tile column
   assign prod  = AW'(trow) * AW'(tpr) + AW'(tcol);
   assign tiled = (prod << TILE_LOG2) | AW'(intile);

   if (SWZ_SUPPORT) begin : g_swz
      always_comb begin
         case (mode)
            TM_XMAJ: flip = swz & (intile[9] ^ intile[10]);
            TM_YMAJ: flip = swz & intile[9];
            default: flip = 1'b0;
         endcase
      end
   end else begin : g_noswz
      assign flip = 1'b0;
   end

   assign addr = (mode == TM_LINEAR) ? prod : (tiled ^ (AW'(flip) << SWZ_BIT));

endmodule

// File: rtl/tsa_addr_gen.sv
`timescale 1ns/1ps
module tsa_addr_gen
   import tsa_pkg::*;
#(
   parameter int XW           = 14,
   parameter int YW           = 14,
   parameter int PW           = 16,
   parameter int AW           = 32,
   parameter int BPPW         = 3,
   parameter int MAX_BPP_LOG2 = 4,
   parameter bit SWZ_SUPPORT  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [XW-1:0]   req_x,
   input  logic [YW-1:0]   req_y,
   input  logic [PW-1:0]   req_pitch,
   input  logic [1:0]      req_mode,
   input  logic [BPPW-1:0] req_bpp,
   input  logic            req_swz,
   input  logic            req_walk,
   input  logic [XW-1:0]   req_wm1,
   input  logic [YW-1:0]   req_hm1,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [AW-1:0]   out_addr,
   output logic            out_last
);

   localparam int UBW = XW + MAX_BPP_LOG2;

   if (XW < 6 || YW < 6 || UBW < 9 || PW < 10 || AW < 13 ||
       AW < UBW || AW < PW || AW < YW ||
       ((1 << BPPW) - 1) < MAX_BPP_LOG2) begin : g_bad_cfg
      $error("tsa_addr_gen: parameter set out of range");
   end

   logic            adv;
   logic            g_valid, g_swz, g_last;
   logic [XW-1:0]   g_x;
   logic [YW-1:0]   g_y;
   logic [PW-1:0]   g_pitch;
   tile_mode_e      g_mode;
   logic [BPPW-1:0] g_bpp;

   logic [YW-1:0]   sp_trow;
   logic [UBW-1:0]  sp_tcol;
   logic [PW-1:0]   sp_tpr;
   logic [11:0]     sp_intile;

   logic            s1_valid, s1_swz, s1_last;
   tile_mode_e      s1_mode;
   logic [BPPW-1:0] s1_bpp;
   logic [YW-1:0]   s1_trow;
   logic [UBW-1:0]  s1_tcol;
   logic [PW-1:0]   s1_tpr;
   logic [11:0]     s1_intile;
   logic [AW-1:0]   pl_addr;

   // whole pipeline moves when the output slot is free or being taken
   assign adv = ~out_valid | out_ready;

   tsa_walker #(.XW(XW), .YW(YW), .PW(PW), .BPPW(BPPW)) i_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_x     (req_x),
      .req_y     (req_y),
      .req_pitch (req_pitch),
      .req_mode  (tile_mode_e'(req_mode)),
      .req_bpp   (req_bpp),
      .req_swz   (req_swz),
      .req_walk  (req_walk),
      .req_wm1   (req_wm1),
      .req_hm1   (req_hm1),
      .adv       (adv),
      .g_valid   (g_valid),
      .g_x       (g_x),
      .g_y       (g_y),
      .g_pitch   (g_pitch),
      .g_mode    (g_mode),
      .g_bpp     (g_bpp),
      .g_swz     (g_swz),
      .g_last    (g_last)
   );

   tsa_split #(.XW(XW), .YW(YW), .PW(PW), .BPPW(BPPW),
               .MAX_BPP_LOG2(MAX_BPP_LOG2), .UBW(UBW)) i_split (
      .x      (g_x),
      .y      (g_y),
      .pitch  (g_pitch),
      .mode   (g_mode),
      .bpp    (g_bpp),
      .trow   (sp_trow),
      .tcol   (sp_tcol),
      .tpr    (sp_tpr),
      .intile (sp_intile)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         out_valid <= 1'b0;
      end else if (adv) begin
         s1_valid  <= g_valid;
         out_valid <= s1_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         s1_mode   <= g_mode;
         s1_swz    <= g_swz;
         s1_last   <= g_last;
         s1_bpp    <= g_bpp;
         s1_trow   <= sp_trow;
         s1_tcol   <= sp_tcol;
         s1_tpr    <= sp_tpr;
         s1_intile <= sp_intile;
      end
   end

   // R6
   elem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && (s1_mode == TM_XMAJ || s1_mode == TM_YMAJ) &&
      (s1_bpp <= BPPW'(MAX_BPP_LOG2))
      |-> ((s1_intile & ((12'd1 << s1_bpp) - 12'd1)) == 12'd0));

   tsa_place #(.YW(YW), .UBW(UBW), .PW(PW), .AW(AW),
               .SWZ_SUPPORT(SWZ_SUPPORT)) i_place (
      .mode   (s1_mode),
      .swz    (s1_swz),
      .trow   (s1_trow),
      .tcol   (s1_tcol),
      .tpr    (s1_tpr),
      .intile (s1_intile),
      .addr   (pl_addr)
   );

   always_ff @(posedge clk) begin
      if (adv) begin
         out_addr <= pl_addr;
         out_last <= s1_last;
      end
   end

   // R9
   fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && adv |=> out_valid);

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_last));

endmodule

// File: tb/test_tsa_addr_gen.sv
`timescale 1ns/1ps
module test_tsa_addr_gen;

   localparam int CLK_PERIOD = 10;

   logic        clk, rst_n;
   logic        req_valid, req_ready;
   logic [13:0] req_x, req_y;
   logic [15:0] req_pitch;
   logic [1:0]  req_mode;
   logic [2:0]  req_bpp;
   logic        req_swz, req_walk;
   logic [13:0] req_wm1, req_hm1;
   logic        out_valid, out_ready, out_last;
   logic [31:0] out_addr;

   tsa_addr_gen i_tsa_addr_gen (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_x(req_x), .req_y(req_y), .req_pitch(req_pitch),
      .req_mode(req_mode), .req_bpp(req_bpp), .req_swz(req_swz),
      .req_walk(req_walk), .req_wm1(req_wm1), .req_hm1(req_hm1),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_last(out_last)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int     n_checks = 0;
   int     n_fail   = 0;
   bit     bp_on    = 1'b0;
   bit     done     = 1'b0;
   logic [31:0] lfsr = 32'h1234_5678;

   longint exp_a [$];
   bit     exp_l [$];
   string  exp_t [$];

   task automatic chk(bit ok, string tag, string what, longint act, longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   function automatic longint ref_addr(int x, int y, int pitch, int mode, int bpp, int swz);
      longint ub, tile, inner, a;
      int eb, u, v;
      eb = (bpp > 4) ? 4 : bpp;
      ub = longint'(x) * (longint'(1) << eb);
      tile = 0; inner = 0;
      case (mode)
         0: return (longint'(y) * pitch + ub) & 64'hFFFF_FFFF;
         1: begin
            tile  = longint'(y / 8) * (pitch / 512) + ub / 512;
            inner = longint'(y % 8) * 512 + ub % 512;
         end
         2: begin
            tile  = longint'(y / 32) * (pitch / 128) + ub / 128;
            inner = ((ub % 128) / 16) * 512 + longint'(y % 32) * 16 + ub % 16;
         end
         default: begin
            u = x % 64; v = y % 64;
            tile  = longint'(y / 64) * (pitch / 128) + x / 64;
            inner = (u % 2) + ((v % 2) * 2) + (((u / 2) % 2) * 4) + (((v / 2) % 2) * 8)
                  + (((u / 4) % 2) * 16) + ((v / 4) * 32) + ((u / 8) * 512);
         end
      endcase
      a = tile * 4096 + inner;
      if (swz != 0 && mode == 1) a = a ^ ((((a >> 9) ^ (a >> 10)) & 1) << 6);
      if (swz != 0 && mode == 2) a = a ^ (((a >> 9) & 1) << 6);
      return a & 64'hFFFF_FFFF;
   endfunction

   function automatic string tag_for(int mode, int bpp, int swz, int walk);
      if (walk != 0) return "R11";
      if (mode == 0) return "R2";
      if (swz != 0 && mode == 1) return "R7";
      if (swz != 0) return "R8";
      if (bpp != 0 && mode != 3) return "R6";
      if (mode == 1) return "R3";
      if (mode == 2) return "R4";
      return "R5";
   endfunction

   task automatic push_req(int x, int y, int pitch, int mode, int bpp, int swz,
                           int walk, int wm1, int hm1);
      int w, h;
      string t;
      w = (walk != 0) ? wm1 : 0;
      h = (walk != 0) ? hm1 : 0;
      t = tag_for(mode, bpp, swz, walk);
      for (int yy = 0; yy <= h; yy++) begin
         for (int xx = 0; xx <= w; xx++) begin
            exp_a.push_back(ref_addr(x + xx, y + yy, pitch, mode, bpp, swz));
            exp_l.push_back((xx == w) && (yy == h));
            exp_t.push_back(t);
         end
      end
   endtask

   // called at a falling edge; returns at a falling edge with req_valid low
   task automatic send(int x, int y, int pitch, int mode, int bpp, int swz,
                       int walk, int wm1, int hm1);
      req_x     = 14'(x);
      req_y     = 14'(y);
      req_pitch = 16'(pitch);
      req_mode  = 2'(mode);
      req_bpp   = 3'(bpp);
      req_swz   = 1'(swz);
      req_walk  = 1'(walk);
      req_wm1   = 14'(wm1);
      req_hm1   = 14'(hm1);
      req_valid = 1'b1;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      push_req(x, y, pitch, mode, bpp, swz, walk, wm1, hm1);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // output pacing
   always @(negedge clk) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      out_ready = bp_on ? (lfsr[2] | lfsr[5]) : 1'b1;
   end

   // reference comparison on every cycle
   bit          prev_stall = 1'b0;
   logic [31:0] prev_addr  = '0;
   logic        prev_last  = 1'b0;

   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         if (prev_stall)
            chk(out_valid && out_addr == prev_addr && out_last == prev_last,
                "R10", "output changed while stalled", longint'(out_addr), longint'(prev_addr));
         if (out_valid && out_ready) begin
            if (exp_a.size() == 0) begin
               chk(1'b0, "R11", "unexpected address", longint'(out_addr), 0);
            end else begin
               longint ea;
               bit el;
               string et;
               ea = exp_a.pop_front();
               el = exp_l.pop_front();
               et = exp_t.pop_front();
               chk({32'b0, out_addr} == ea, et, "address", longint'(out_addr), ea);
               chk(out_last == el, "R12", "last flag", longint'(out_last), longint'(el));
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_addr  = out_addr;
         prev_last  = out_last;
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R11", "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      int r;
      rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b1;
      req_x = '0; req_y = '0; req_pitch = '0; req_mode = '0; req_bpp = '0;
      req_swz = 1'b0; req_walk = 1'b0; req_wm1 = '0; req_hm1 = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
      chk(req_ready == 1'b1, "R1", "req_ready after reset", longint'(req_ready), 1);
      @(negedge clk);

      // R9: two register stages
      send(20, 5, 2048, 1, 2, 0, 0, 0, 0);
      #2;
      chk(out_valid == 1'b0, "R9", "valid one edge after accept", longint'(out_valid), 0);
      @(negedge clk);
      #2;
      chk(out_valid == 1'b1, "R9", "valid two edges after accept", longint'(out_valid), 1);
      @(negedge clk);

      // R2 linear, swizzle ignored
      send(10, 3, 1000, 0, 0, 1, 0, 0, 0);
      send(7, 2, 640, 0, 3, 0, 0, 0, 0);
      send(300, 99, 4096, 0, 2, 1, 0, 0, 0);
      // R3 X layout, tile edges
      send(511, 7, 2048, 1, 0, 0, 0, 0, 0);
      send(512, 8, 2048, 1, 0, 0, 0, 0, 0);
      send(1000, 23, 4096, 1, 1, 0, 0, 0, 0);
      // R7 X swizzle: row 1 flips, row 3 cancels, row 6 flips
      send(64, 1, 2048, 1, 0, 1, 0, 0, 0);
      send(64, 3, 2048, 1, 0, 1, 0, 0, 0);
      send(70, 14, 2048, 1, 0, 1, 0, 0, 0);
      // R4 Y layout
      send(31, 31, 1024, 2, 2, 0, 0, 0, 0);
      send(32, 32, 1024, 2, 2, 0, 0, 0, 0);
      send(200, 40, 1024, 2, 0, 0, 0, 0, 0);
      // R6 wide elements
      send(5, 9, 1024, 2, 4, 0, 0, 0, 0);
      send(37, 9, 2048, 1, 4, 0, 0, 0, 0);
      send(13, 4, 1024, 2, 7, 0, 0, 0, 0);
      // R8 Y swizzle on bit 9 only, W never swizzled
      send(16, 2, 1024, 2, 0, 1, 0, 0, 0);
      send(48, 2, 1024, 2, 0, 1, 0, 0, 0);
      send(100, 70, 512, 3, 3, 1, 0, 0, 0);
      // R5 W layout
      send(63, 63, 512, 3, 0, 0, 0, 0, 0);
      send(64, 64, 512, 3, 0, 0, 0, 0, 0);
      send(129, 5, 1024, 3, 2, 0, 0, 0, 0);
      // R12 single request ignores rectangle size
      send(3, 3, 2048, 1, 0, 0, 0, 5, 5);

      // R11 walks
      send(510, 6, 2048, 1, 0, 0, 1, 4, 2);
      send(30, 30, 1024, 2, 2, 1, 1, 3, 3);
      send(60, 62, 512, 3, 0, 0, 1, 5, 3);
      send(9, 1, 700, 0, 1, 0, 1, 2, 1);
      send(127, 0, 1024, 2, 0, 0, 1, 0, 4);
      send(4, 4, 2048, 1, 0, 0, 1, 0, 0);

      // backpressure phase
      bp_on = 1'b1;
      send(600, 9, 2048, 1, 0, 1, 0, 0, 0);
      send(33, 17, 1024, 2, 3, 0, 1, 6, 2);
      send(0, 0, 512, 3, 0, 0, 1, 3, 3);
      for (int i = 0; i < 60; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         r = int'(lfsr & 32'h7FFF_FFFF);
         send(r % 2000, (r >> 11) % 1500, (((r >> 17) % 8) + 1) * 512,
              (r >> 3) & 3, (r >> 7) % 5, (r >> 13) & 1, 0, 0, 0);
      end
      bp_on = 1'b0;

      for (int i = 0; i < 2000 && exp_a.size() != 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(exp_a.size() == 0, "R11", "addresses outstanding", longint'(exp_a.size()), 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule